// File: doc/BRIEF.md
# I2S Receiver with Clock-Slip Mute

This block takes a three-wire serial audio stream (bit clock, word clock, serial data) and turns it into parallel signed left and right samples. It runs entirely in a system-clock domain at 256 times the sample rate. The bit clock runs at 64 times the sample rate. All three serial wires pass through two-flop synchronisers. Edges of the bit clock and word clock are then detected in the system-clock domain, and the data wire is sampled on each detected bit-clock rise.

A 3-bit format code selects 16-bit or 24-bit I2S word length. Short words are sign-extended to the 24-bit output. The block also measures the phase of each word-clock falling edge against a free-running counter that wraps once per frame. If that phase moves more than six bit-clock periods away from the locked reference, the block mutes at once and forces zero samples. It stays muted until the phase has held steady for four further frames.

Top module: `i2srx_top`

## Requirements
- R1: The data wire is sampled on each rising bit-clock edge. The most significant bit arrives on the second rising edge after a word-clock transition, and words are two's complement. Word clock low carries the left channel and high carries the right channel. With format code 3'b101 the 24 received bits appear unchanged on the output.
- R2: With format code 3'b100 only the first 16 bits of each 32-bit slot are used. The 16-bit word appears sign-extended on the 24-bit output.
- R3: Any format code other than 3'b100, including 3'b000 and 3'b111, decodes as 24-bit I2S. Slot bits after the selected word length, and the bit at the word-clock transition, have no effect on the output.
- R4: The format code is sampled once per frame, at the start of the left slot. A change in the middle of a frame first affects the following frame. The format register resets to 24-bit.
- R5: `valid_out` is a one-cycle strobe, issued once per frame after the right word completes. `left_out` and `right_out` hold the frame's pair until the next strobe.
- R6: During reset `mute_out` is 1, `valid_out` is 0, and both sample outputs are 0.
- R7: After reset, the first word-clock falling edge records a phase. `mute_out` clears at the fifth falling edge, provided the four edges after the first each lie within ±1 system clock of the edge before. The phase of that fifth edge becomes the reference.
- R8: While muted, every strobed sample pair is zero.
- R9: While locked, a word-clock phase offset of up to 6 bit clocks (24 system clocks) from the reference does not mute, and samples keep decoding.
- R10: While locked, a phase offset beyond 24 system clocks sets `mute_out` at that word-clock falling edge. `mute_out` clears after four more consistent frames, and decoding then resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 256 times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous to `clk` edges |
| wclk_in | input | 1 | Serial word clock (low = left, high = right) |
| sdata_in | input | 1 | Serial data, MSB first |
| fmt_in | input | 3 | Format code: 3'b100 16-bit, other codes 24-bit |
| left_out | output | 24 | Signed left sample |
| right_out | output | 24 | Signed right sample |
| valid_out | output | 1 | One-cycle strobe for a new sample pair |
| mute_out | output | 1 | High while resynchronising; samples forced to zero |

## Verification
A word-clock edge driven by the bench reaches `mute_out` three system clocks later: two synchroniser flops, then the phase register. The bench therefore samples `mute_out` eight cycles after each edge it drives, which leaves margin while staying well inside the same frame. Samples appear about four system clocks after the bit-clock rise that carries the last used bit. The bench polls for the strobe at falling clock edges within a bounded window, compares the pair at that cycle, and checks that the strobe is low one cycle later. Phase offsets are applied in the middle of a left slot. Only the word-clock edges after the change are judged for mute, and the corrupted frame is never compared.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int SHORT_W  = 16;

    typedef enum logic [2:0] {
        FMT_I2S16 = 3'b100,
        FMT_I2S24 = 3'b101
    } fmt_code_e;

    typedef enum logic {
        WL_24 = 1'b0,
        WL_16 = 1'b1
    } wlen_e;

    // serial lines after synchronisation
    typedef struct packed {
        logic sd;
        logic wclk;
        logic bclk;
    } serial_t;

    function automatic wlen_e decode_fmt(input logic [2:0] code);
        return (code == FMT_I2S16) ? WL_16 : WL_24;
    endfunction

    function automatic logic [SAMPLE_W-1:0] sext_short(input logic [SHORT_W-1:0] w);
        return {{(SAMPLE_W-SHORT_W){w[SHORT_W-1]}}, w};
    endfunction

endpackage

// File: rtl/i2srx_sync.sv
module i2srx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/i2srx_deser.sv
module i2srx_deser
    import i2srx_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_rise,
    input  logic                wclk_lvl,
    input  logic                sd_lvl,
    input  logic [2:0]          fmt_in,
    output logic                word_done,
    output logic                word_chan,
    output logic [SAMPLE_W-1:0] word_val
);
    localparam int POS_W = $clog2(SLOT_W + 1);

    logic                  wclk_prev_q;
    logic [POS_W-1:0]      pos_q;
    logic                  chan_q;
    wlen_e                 wl_q;
    logic [SAMPLE_W-2:0]   shift_q;
    logic [SAMPLE_W-1:0]   shift_nx;
    logic [POS_W-1:0]      wl_bits;

    assign shift_nx = {shift_q, sd_lvl};
    assign wl_bits  = (wl_q == WL_16) ? POS_W'(SHORT_W) : POS_W'(SAMPLE_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            wclk_prev_q <= 1'b0;
            pos_q       <= '0;
            chan_q      <= 1'b0;
            wl_q        <= WL_24;
            shift_q     <= '0;
            word_done   <= 1'b0;
            word_chan   <= 1'b0;
            word_val    <= '0;
        end else begin
            word_done <= 1'b0;
            if (bclk_rise) begin
                wclk_prev_q <= wclk_lvl;
                if (wclk_lvl != wclk_prev_q) begin
                    // the bit at the transition belongs to the previous slot
                    pos_q  <= '0;
                    chan_q <= wclk_lvl;
                    if (!wclk_lvl) begin
                        wl_q <= decode_fmt(fmt_in);
                    end
                end else begin
                    if (pos_q < wl_bits) begin
                        shift_q <= shift_nx[SAMPLE_W-2:0];
                        if (pos_q == wl_bits - 1'b1) begin
                            word_done <= 1'b1;
                            word_chan <= chan_q;
                            word_val  <= (wl_q == WL_16) ? sext_short(shift_nx[SHORT_W-1:0])
                                                         : shift_nx;
                        end
                    end
                    if (pos_q < POS_W'(SLOT_W)) begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
            end
        end
    end

    // R5: a finished word is flagged for one cycle only
    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        word_done |=> !word_done);

    // R2: short words leave the upper byte equal to their sign bit
    assert_short_sext_R2: assert property (@(posedge clk) disable iff (rst)
        (word_done && wl_q == WL_16) |->
            (word_val[SAMPLE_W-1:SHORT_W] == {(SAMPLE_W-SHORT_W){word_val[SHORT_W-1]}}));
endmodule

// File: rtl/i2srx_phase.sv
module i2srx_phase #(
    parameter int SYS_PER_FRAME   = 256,
    parameter int BCLK_PER_FRAME  = 64,
    parameter int SLIP_LIMIT_BCLK = 6,
    parameter int LOCK_TOL_SYS    = 1,
    parameter int LOCK_FRAMES     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wclk_fall,
    output logic mute
);
    localparam int CNT_W    = $clog2(SYS_PER_FRAME);
    localparam int SLIP_SYS = SLIP_LIMIT_BCLK * (SYS_PER_FRAME / BCLK_PER_FRAME);
    localparam int GOOD_W   = $clog2(LOCK_FRAMES + 1);
    localparam logic [CNT_W-1:0]  SLIP_V = CNT_W'(SLIP_SYS);
    localparam logic [CNT_W-1:0]  TOL_V  = CNT_W'(LOCK_TOL_SYS);
    localparam logic [GOOD_W-1:0] LAST_GOOD = GOOD_W'(LOCK_FRAMES - 1);

    function automatic logic [CNT_W-1:0] circ_dist(input logic [CNT_W-1:0] a,
                                                   input logic [CNT_W-1:0] b);
        logic [CNT_W-1:0] d;
        d = a - b;
        return d[CNT_W-1] ? (~d + 1'b1) : d;
    endfunction

    logic [CNT_W-1:0]  frame_ctr_q;
    logic [CNT_W-1:0]  prev_ph_q;
    logic [CNT_W-1:0]  ref_ph_q;
    logic [GOOD_W-1:0] good_q;
    logic              have_prev_q;
    logic              near_prev;
    logic              far_ref;

    assign near_prev = circ_dist(frame_ctr_q, prev_ph_q) <= TOL_V;
    assign far_ref   = circ_dist(frame_ctr_q, ref_ph_q) > SLIP_V;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_ctr_q <= '0;
            prev_ph_q   <= '0;
            ref_ph_q    <= '0;
            good_q      <= '0;
            have_prev_q <= 1'b0;
            mute        <= 1'b1;
        end else begin
            frame_ctr_q <= frame_ctr_q + 1'b1;
            if (wclk_fall) begin
                if (mute) begin
                    prev_ph_q   <= frame_ctr_q;
                    have_prev_q <= 1'b1;
                    if (have_prev_q && near_prev) begin
                        if (good_q == LAST_GOOD) begin
                            mute     <= 1'b0;
                            ref_ph_q <= frame_ctr_q;
                            good_q   <= '0;
                        end else begin
                            good_q <= good_q + 1'b1;
                        end
                    end else begin
                        good_q <= '0;
                    end
                end else if (far_ref) begin
                    mute        <= 1'b1;
                    prev_ph_q   <= frame_ctr_q;
                    have_prev_q <= 1'b1;
                    good_q      <= '0;
                end
            end
        end
    end

    // R7: lock is only granted on a word-clock frame boundary
    assert_unmute_on_edge_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(mute) |-> $past(wclk_fall));

    // R10: a slip mutes only on a word-clock frame boundary
    assert_slip_on_edge_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(mute) |-> $past(wclk_fall));
endmodule

// File: rtl/i2srx_top.sv
module i2srx_top
    import i2srx_pkg::*;
#(
    parameter int SYS_PER_FRAME   = 256,
    parameter int BCLK_PER_FRAME  = 64,
    parameter int SLIP_LIMIT_BCLK = 6,
    parameter int LOCK_TOL_SYS    = 1,
    parameter int LOCK_FRAMES     = 4,
    parameter int SYNC_STAGES     = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bclk_in,
    input  logic                       wclk_in,
    input  logic                       sdata_in,
    input  logic [2:0]                 fmt_in,
    output logic signed [SAMPLE_W-1:0] left_out,
    output logic signed [SAMPLE_W-1:0] right_out,
    output logic                       valid_out,
    output logic                       mute_out
);
    localparam int SLOT_W = BCLK_PER_FRAME / 2;

    serial_t ser_raw;
    serial_t ser_s;
    logic    bclk_prev_q;
    logic    wclk_prev_q;
    logic    bclk_rise;
    logic    wclk_fall;

    logic                word_done;
    logic                word_chan;
    logic [SAMPLE_W-1:0] word_val;
    logic [SAMPLE_W-1:0] left_hold_q;

    assign ser_raw = '{sd: sdata_in, wclk: wclk_in, bclk: bclk_in};

    i2srx_sync #(.W($bits(serial_t)), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (ser_raw),
        .sync_out (ser_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_prev_q <= 1'b0;
            wclk_prev_q <= 1'b0;
        end else begin
            bclk_prev_q <= ser_s.bclk;
            wclk_prev_q <= ser_s.wclk;
        end
    end

    assign bclk_rise = ser_s.bclk & ~bclk_prev_q;
    assign wclk_fall = wclk_prev_q & ~ser_s.wclk;

    i2srx_deser #(.SLOT_W(SLOT_W)) deser_i (
        .clk       (clk),
        .rst       (rst),
        .bclk_rise (bclk_rise),
        .wclk_lvl  (ser_s.wclk),
        .sd_lvl    (ser_s.sd),
        .fmt_in    (fmt_in),
        .word_done (word_done),
        .word_chan (word_chan),
        .word_val  (word_val)
    );

    i2srx_phase #(
        .SYS_PER_FRAME   (SYS_PER_FRAME),
        .BCLK_PER_FRAME  (BCLK_PER_FRAME),
        .SLIP_LIMIT_BCLK (SLIP_LIMIT_BCLK),
        .LOCK_TOL_SYS    (LOCK_TOL_SYS),
        .LOCK_FRAMES     (LOCK_FRAMES)
    ) phase_i (
        .clk       (clk),
        .rst       (rst),
        .wclk_fall (wclk_fall),
        .mute      (mute_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold_q <= '0;
            left_out    <= '0;
            right_out   <= '0;
            valid_out   <= 1'b0;
        end else begin
            valid_out <= 1'b0;
            if (word_done && !word_chan) begin
                left_hold_q <= word_val;
            end
            if (word_done && word_chan) begin
                valid_out <= 1'b1;
                left_out  <= mute_out ? '0 : left_hold_q;
                right_out <= mute_out ? '0 : word_val;
            end
        end
    end

    // R8: a pair strobed while muted carries zeros
    assert_mute_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_out && $past(mute_out)) |-> (left_out == '0 && right_out == '0));

    // R5: outputs only move together with the strobe
    assert_hold_between_R5: assert property (@(posedge clk) disable iff (rst)
        !valid_out |=> (valid_out || ($stable(left_out) && $stable(right_out))));
endmodule

// File: tb/i2srx_top_tb_top.sv
module i2srx_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [7:0]  t = '0;
    logic [7:0]  off = '0;
    logic [7:0]  tt;
    logic [23:0] cur_l = '0;
    logic [23:0] cur_r = '0;
    int          gen_wl = 24;
    logic [2:0]  fmt_b = 3'b101;
    logic        bclk_b, wclk_b, sd_b;

    logic signed [23:0] left_out, right_out;
    logic               valid_out, mute_out;

    int n_chk  = 0;
    int n_fail = 0;

    always @(negedge clk) t <= t + 1'b1;

    function automatic logic sd_bit(input logic [7:0] x, input logic [23:0] l,
                                    input logic [23:0] r, input int wl);
        int k;
        logic [23:0] w;
        k = int'(x[6:2]);
        w = x[7] ? r : l;
        if (k >= 1 && k <= wl) return w[wl-k];
        return 1'b1;
    endfunction

    assign tt     = t + off;
    assign bclk_b = tt[1];
    assign wclk_b = tt[7];
    assign sd_b   = sd_bit(tt, cur_l, cur_r, gen_wl);

    i2srx_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .bclk_in   (bclk_b),
        .wclk_in   (wclk_b),
        .sdata_in  (sd_b),
        .fmt_in    (fmt_b),
        .left_out  (left_out),
        .right_out (right_out),
        .valid_out (valid_out),
        .mute_out  (mute_out)
    );

    localparam logic [50:0] VEC [0:5] = '{
        {3'b101, 24'h7FFFFF, 24'h800000},
        {3'b101, 24'h123456, 24'hFEDCBA},
        {3'b100, 24'h007FFF, 24'h008000},
        {3'b100, 24'h001234, 24'h00F00F},
        {3'b000, 24'hA5A5A5, 24'h5A5A5A},
        {3'b111, 24'h000001, 24'hFFFFFF}
    };

    function automatic logic [23:0] expect_word(input logic [2:0] f, input logic [23:0] w);
        if (f == 3'b100) return {{8{w[15]}}, w[15:0]};
        return w;
    endfunction

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_valid(input string tag);
        bit seen;
        seen = 0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            if (valid_out) seen = 1;
        end
        if (!seen) begin
            n_chk++;
            n_fail++;
            $display("FAIL %s actual=no strobe expected=strobe", tag);
        end
    endtask

    task automatic start_frame(input logic [2:0] f, input logic [23:0] l, input logic [23:0] r);
        @(negedge wclk_b);
        fmt_b  = f;
        gen_wl = (f == 3'b100) ? 16 : 24;
        cur_l  = l;
        cur_r  = r;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        // R6 reset state
        chk("R6 mute", 24'(mute_out), 24'd1);
        chk("R6 valid", 24'(valid_out), 24'd0);
        chk("R6 left", left_out, 24'd0);
        chk("R6 right", right_out, 24'd0);
        rst = 1'b0;

        // R7 / R8 lock acquisition after reset
        for (int i = 1; i <= 5; i++) begin
            start_frame(3'b101, 24'hAAAAAA, 24'h555555);
            repeat (8) @(negedge clk);
            if (i == 2) begin
                wait_valid("R8");
                chk("R8 left zero", left_out, 24'd0);
                chk("R8 right zero", right_out, 24'd0);
                chk("R8 muted", 24'(mute_out), 24'd1);
            end
            if (i == 4) chk("R7 still muted at 4th edge", 24'(mute_out), 24'd1);
            if (i == 5) chk("R7 unmuted at 5th edge", 24'(mute_out), 24'd0);
        end

        // vector table: R1 24-bit, R2 16-bit, R3 other codes
        for (int v = 0; v < 6; v++) begin
            logic [2:0]  f;
            string       tag;
            f = VEC[v][50:48];
            tag = (f == 3'b100) ? "R2" : ((f == 3'b101) ? "R1" : "R3");
            start_frame(f, VEC[v][47:24], VEC[v][23:0]);
            wait_valid(tag);
            chk({tag, " left"}, left_out, expect_word(f, VEC[v][47:24]));
            chk({tag, " right"}, right_out, expect_word(f, VEC[v][23:0]));
            if (v == 0) begin
                @(negedge clk);
                chk("R5 strobe width", 24'(valid_out), 24'd0);
                chk("R5 hold left", left_out, 24'h7FFFFF);
            end
        end

        // R4 format change mid-frame applies next frame
        start_frame(3'b101, 24'h8F0001, 24'h00F0F1);
        repeat (40) @(negedge clk);
        fmt_b = 3'b100;
        wait_valid("R4");
        chk("R4 left keeps 24-bit", left_out, 24'h8F0001);
        chk("R4 right keeps 24-bit", right_out, 24'h00F0F1);
        start_frame(3'b100, 24'h00ABCD, 24'h001357);
        wait_valid("R4");
        chk("R4 left next frame", left_out, 24'hFFABCD);
        chk("R4 right next frame", right_out, 24'h001357);

        // R9 phase offset of exactly 24 system clocks tolerated
        start_frame(3'b101, 24'h0, 24'h0);
        repeat (100) @(negedge clk);
        off = off + 8'd24;
        @(negedge wclk_b);
        repeat (8) @(negedge clk);
        chk("R9 no mute at 24", 24'(mute_out), 24'd0);
        start_frame(3'b101, 24'h3C3C3C, 24'hC3C3C3);
        wait_valid("R9");
        chk("R9 left", left_out, 24'h3C3C3C);
        chk("R9 right", right_out, 24'hC3C3C3);

        // R10 offset of 28 system clocks mutes, then relocks
        repeat (10) @(negedge clk);
        off = off + 8'd4;
        @(negedge wclk_b);
        repeat (8) @(negedge clk);
        chk("R10 mute on slip", 24'(mute_out), 24'd1);
        for (int j = 1; j <= 4; j++) begin
            start_frame(3'b101, 24'h111111, 24'h222222);
            repeat (8) @(negedge clk);
            if (j == 3) chk("R10 still muted", 24'(mute_out), 24'd1);
            if (j == 4) chk("R10 relocked", 24'(mute_out), 24'd0);
        end
        wait_valid("R10");
        chk("R10 left after relock", left_out, 24'h111111);
        chk("R10 right after relock", right_out, 24'h222222);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule